// File: doc/BRIEF.md
# Dual-Port Paired-Page Translation Buffer

This block is a fully associative address translation cache for a 32-bit virtual space. Each entry covers two neighbouring virtual pages that share one tag. One physical frame number, one valid bit and one dirty bit belong to the lower ("even") page, and another set belongs to the upper ("odd") page. Every entry carries its own page size, from 4 KiB up to 256 MiB in steps of four. Tag bits that fall inside a larger page take no part in the compare. The virtual address bit just above the page offset picks which of the two pages applies.

Two lookup ports work in parallel in every cycle. One serves instruction fetch and one serves data accesses. Each port takes a virtual address and the current address-space identifier. One cycle later it returns exactly one outcome: a translation with its physical address and dirty bit, a miss, an invalid-page fault or, for data stores only, a modified-page fault. Software or a refill engine fills entries through an indexed write port. A probe port reports whether a tag is present and at which index, so that a refill can replace an entry that already exists.

Top module: `ptlb_top`

## Requirements
- R1: After synchronous reset no entry is present. Every lookup then reports a miss, every probe reports no hit, and all outputs stay low until a request arrives.
- R2: A write to index `wr_idx` changes that entry for lookups and probes presented from the next cycle onward. A lookup presented in the same cycle as the write sees the old contents. Indices at or above the entry count are ignored.
- R3: An entry matches a request when three things hold. It has been written since reset. Its tag equals VA[31:13] in every bit that its page size does not ignore. Its global bit is set, or its 8-bit identifier equals `cur_asid`.
- R4: Size code k in 0..8 selects a page of 4 KiB·4^k, and tag bits VA[13+2k-1:13] are ignored. Codes 9 to 15 act as code 8 (256 MiB).
- R5: VA bit 12+2k selects the half. A value of 0 selects the even frame, valid and dirty bits, and a value of 1 selects the odd set.
- R6: On a translation, the physical address holds the selected frame number in bits [31:12]. Bits [12+2k-1:0] of that value are replaced by the same bits of the VA.
- R7: A request whose matching half has its valid bit clear reports an invalid fault. It reports neither hit nor miss, and the address and dirty outputs are zero. Each answered request raises exactly one of hit, miss, invalid or modified.
- R8: A data store whose matching half is valid but has a clear dirty bit reports a modified fault. Hit is low and the address is zero. A load of the same page is a hit with dirty low.
- R9: Each lookup port answers in the cycle after its request, with `*_ack` high. Both ports are answered in the same cycle independently. Without a request, `*_ack` and all flags are low.
- R10: When several entries match, the lowest index supplies the result.
- R11: A probe answers one cycle later with `pr_hit` and the lowest matching index, using the match rule of R3 and ignoring valid bits. `pr_idx` is zero when there is no hit.
- R12: The instruction port never raises a modified fault. Its `i_dirty` output reports the dirty bit of the selected half on a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_asid | input | 8 | Identifier of the running address space |
| i_req | input | 1 | Instruction lookup request |
| i_va | input | 32 | Instruction virtual address |
| i_ack | output | 1 | Instruction result valid |
| i_hit | output | 1 | Instruction translation found |
| i_miss | output | 1 | No entry matched |
| i_inval | output | 1 | Matching half not valid |
| i_pa | output | 32 | Instruction physical address |
| i_dirty | output | 1 | Dirty bit of the translated page |
| d_req | input | 1 | Data lookup request |
| d_va | input | 32 | Data virtual address |
| d_store | input | 1 | Data access is a store |
| d_ack | output | 1 | Data result valid |
| d_hit | output | 1 | Data translation found |
| d_miss | output | 1 | No entry matched |
| d_inval | output | 1 | Matching half not valid |
| d_mod | output | 1 | Store to a clean page |
| d_pa | output | 32 | Data physical address |
| d_dirty | output | 1 | Dirty bit of the translated page |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn2 | input | 19 | Pair tag, VA[31:13] |
| wr_asid | input | 8 | Entry identifier |
| wr_global | input | 1 | Match any identifier |
| wr_size | input | 4 | Page size code |
| wr_pfn_even | input | 20 | Even frame number |
| wr_valid_even | input | 1 | Even half valid |
| wr_dirty_even | input | 1 | Even half writable |
| wr_pfn_odd | input | 20 | Odd frame number |
| wr_valid_odd | input | 1 | Odd half valid |
| wr_dirty_odd | input | 1 | Odd half writable |
| pr_req | input | 1 | Probe request |
| pr_va | input | 32 | Probe virtual address |
| pr_ack | output | 1 | Probe result valid |
| pr_hit | output | 1 | Probe found an entry |
| pr_idx | output | 4 | Lowest matching index |

## Verification
The assertions assume that `d_store` is sampled only along with `d_req`. They also assume that each request input is a clean single-cycle pulse, with address and identifier stable within that cycle. They do not assume single matches, because R10 defines which entry wins when several match. The bench drives every input at the falling edge and holds it for a whole cycle. It deliberately creates overlapping entries, entries written in the same cycle as a lookup, and size codes outside 0..8, so that the rules on priority, write timing and size saturation are exercised.

// File: rtl/ptlb_pkg.sv
// Package: shared widths, outcome encoding and size helpers for the
// paired-page translation buffer. Assumes a 32-bit virtual space with a
// 4 KiB base page and page sizes that grow by a factor of four.
package ptlb_pkg;

    localparam int VA_W     = 32;
    localparam int ASID_W   = 8;
    localparam int SZ_W     = 4;
    localparam int MAX_SZ   = 8;
    localparam int PAGE_LSB = 12;
    localparam int TAG_LSB  = PAGE_LSB + 1;
    localparam int VPN2_W   = VA_W - TAG_LSB;

    typedef enum logic [1:0] {
        RES_MISS  = 2'd0,
        RES_HIT   = 2'd1,
        RES_INVAL = 2'd2,
        RES_MOD   = 2'd3
    } res_kind_e;

    // Saturate a size code to the largest supported page.
    function automatic logic [SZ_W-1:0] clamp_size(input logic [SZ_W-1:0] s);
        return (s > SZ_W'(MAX_SZ)) ? SZ_W'(MAX_SZ) : s;
    endfunction

    // Tag bits that take part in the compare for a given size code.
    function automatic logic [VPN2_W-1:0] tag_care(input logic [SZ_W-1:0] s);
        return ~((VPN2_W'(1) << (2 * s)) - VPN2_W'(1));
    endfunction

    // Page-offset bits that pass from the virtual address for a size code.
    function automatic logic [VA_W-1:0] offset_mask(input logic [SZ_W-1:0] s);
        return (VA_W'(1) << (PAGE_LSB + 2 * s)) - VA_W'(1);
    endfunction

endpackage

// File: rtl/ptlb_entry_store.sv
// Entry storage: holds tag, identifier, global flag, size and the two
// half-page records of each entry. Assumes writes use a legal size code
// or accept saturation; writes to indices beyond the entry count are dropped.
module ptlb_entry_store
    import ptlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int PFN_W = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN2_W-1:0] wr_vpn2,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [SZ_W-1:0]   wr_size,
    input  logic [PFN_W-1:0]  wr_pfn_e,
    input  logic              wr_v_e,
    input  logic              wr_d_e,
    input  logic [PFN_W-1:0]  wr_pfn_o,
    input  logic              wr_v_o,
    input  logic              wr_d_o,
    output logic              present [N],
    output logic [VPN2_W-1:0] vpn2    [N],
    output logic [ASID_W-1:0] asid    [N],
    output logic              glob    [N],
    output logic [SZ_W-1:0]   sz      [N],
    output logic [PFN_W-1:0]  pfn_e   [N],
    output logic              v_e     [N],
    output logic              d_e     [N],
    output logic [PFN_W-1:0]  pfn_o   [N],
    output logic              v_o     [N],
    output logic              d_o     [N]
);

    logic wr_ok;

    // Write is accepted only for an index inside the array.
    always_comb wr_ok = wr_en && (int'(wr_idx) < N);

    // Clear all entries on reset, load one entry per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                present[i] <= 1'b0;
                vpn2[i]    <= '0;
                asid[i]    <= '0;
                glob[i]    <= 1'b0;
                sz[i]      <= '0;
                pfn_e[i]   <= '0;
                v_e[i]     <= 1'b0;
                d_e[i]     <= 1'b0;
                pfn_o[i]   <= '0;
                v_o[i]     <= 1'b0;
                d_o[i]     <= 1'b0;
            end
        end else if (wr_ok) begin
            present[wr_idx] <= 1'b1;
            vpn2[wr_idx]    <= wr_vpn2;
            asid[wr_idx]    <= wr_asid;
            glob[wr_idx]    <= wr_global;
            sz[wr_idx]      <= clamp_size(wr_size);
            pfn_e[wr_idx]   <= wr_pfn_e;
            v_e[wr_idx]     <= wr_v_e;
            d_e[wr_idx]     <= wr_d_e;
            pfn_o[wr_idx]   <= wr_pfn_o;
            v_o[wr_idx]     <= wr_v_o;
            d_o[wr_idx]     <= wr_d_o;
        end
    end

    // R2: an accepted write is visible in the array one cycle later.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> present[$past(wr_idx)] && (vpn2[$past(wr_idx)] == $past(wr_vpn2)));

    // R4: stored size codes never exceed the largest page.
    p_size_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (sz[$past(wr_idx)] <= SZ_W'(MAX_SZ)));

endmodule

// File: rtl/ptlb_cam_match.sv
// Associative compare: one match bit per entry for a query tag and
// identifier. Assumes stored size codes are already saturated.
module ptlb_cam_match
    import ptlb_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [VPN2_W-1:0] q_vpn2,
    input  logic [ASID_W-1:0] q_asid,
    input  logic              present [N],
    input  logic [VPN2_W-1:0] vpn2    [N],
    input  logic [ASID_W-1:0] asid    [N],
    input  logic              glob    [N],
    input  logic [SZ_W-1:0]   sz      [N],
    output logic [N-1:0]      match_vec
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic tag_eq;
        logic id_ok;

        // Masked tag compare for this entry.
        always_comb tag_eq = ((vpn2[g] ^ q_vpn2) & tag_care(sz[g])) == '0;

        // Identifier check, bypassed by the global flag.
        always_comb id_ok = glob[g] || (asid[g] == q_asid);

        // Final match bit for this entry.
        always_comb match_vec[g] = present[g] && tag_eq && id_ok;
    end

endmodule

// File: rtl/ptlb_port_resolve.sv
// Lookup result stage for one port: picks the lowest matching entry,
// selects the half, classifies the outcome and forms the physical address,
// then registers it. Assumes PA_W >= VA_W and store is meaningful only with req.
module ptlb_port_resolve
    import ptlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int PA_W  = 32,
    localparam int PFN_W = PA_W - PAGE_LSB,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [VA_W-1:0]  va,
    input  logic             store,
    input  logic [N-1:0]     match_vec,
    input  logic [SZ_W-1:0]  sz    [N],
    input  logic [PFN_W-1:0] pfn_e [N],
    input  logic             v_e   [N],
    input  logic             d_e   [N],
    input  logic [PFN_W-1:0] pfn_o [N],
    input  logic             v_o   [N],
    input  logic             d_o   [N],
    output logic             o_ack,
    output logic             o_hit,
    output logic             o_miss,
    output logic             o_inval,
    output logic             o_mod,
    output logic [PA_W-1:0]  o_pa,
    output logic             o_dirty
);

    logic             found;
    logic [IDX_W-1:0] sel;
    logic [SZ_W-1:0]  sel_sz;
    logic [VA_W-1:0]  va_sh;
    logic             odd;
    logic [PFN_W-1:0] sel_pfn;
    logic             sel_v;
    logic             sel_d;
    logic [PA_W-1:0]  off_m;
    logic [PA_W-1:0]  pa_c;
    res_kind_e        kind;

    // Lowest-index priority pick among matching entries.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                found = 1'b1;
                sel   = IDX_W'(i);
            end
        end
    end

    // Choose even or odd half from the bit above the page offset.
    always_comb begin
        sel_sz  = sz[sel];
        va_sh   = va >> (PAGE_LSB + 2 * sel_sz);
        odd     = va_sh[0];
        sel_pfn = odd ? pfn_o[sel] : pfn_e[sel];
        sel_v   = odd ? v_o[sel]   : v_e[sel];
        sel_d   = odd ? d_o[sel]   : d_e[sel];
    end

    // Merge frame number with the offset bits of the page size.
    always_comb begin
        off_m = PA_W'(offset_mask(sel_sz));
        pa_c  = ({sel_pfn, {PAGE_LSB{1'b0}}} & ~off_m) | (PA_W'(va) & off_m);
    end

    // Classify the outcome of the lookup.
    always_comb begin
        if (!found)               kind = RES_MISS;
        else if (!sel_v)          kind = RES_INVAL;
        else if (store && !sel_d) kind = RES_MOD;
        else                      kind = RES_HIT;
    end

    // Register the answer one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_ack   <= 1'b0;
            o_hit   <= 1'b0;
            o_miss  <= 1'b0;
            o_inval <= 1'b0;
            o_mod   <= 1'b0;
            o_pa    <= '0;
            o_dirty <= 1'b0;
        end else begin
            o_ack   <= req;
            o_hit   <= req && (kind == RES_HIT);
            o_miss  <= req && (kind == RES_MISS);
            o_inval <= req && (kind == RES_INVAL);
            o_mod   <= req && (kind == RES_MOD);
            o_pa    <= (req && kind == RES_HIT) ? pa_c : '0;
            o_dirty <= req && (kind == RES_HIT) && sel_d;
        end
    end

    // R9: an answer follows every request, and only a request.
    p_ack_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> o_ack);
    p_no_spurious_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !o_ack && !o_hit && !o_miss && !o_inval && !o_mod);

    // R7: every answer carries exactly one outcome.
    p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        o_ack |-> ($countones({o_hit, o_miss, o_inval, o_mod}) == 1));

    // R8: a modified fault only answers a store.
    p_mod_needs_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        o_mod |-> $past(req && store));

    // R6: the base-page offset always passes through unchanged.
    p_offset_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        o_hit |-> (o_pa[PAGE_LSB-1:0] == $past(va[PAGE_LSB-1:0])));

endmodule

// File: rtl/ptlb_top.sv
// Paired-page translation buffer top: entry store, two lookup ports
// (instruction and data) and a probe port sharing one match rule.
// Assumes ENTRIES is 16, 32, 48 or 64 and PA_W >= 32.
module ptlb_top
    import ptlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PA_W    = 32,
    localparam int PFN_W  = PA_W - PAGE_LSB,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              i_req,
    input  logic [VA_W-1:0]   i_va,
    output logic              i_ack,
    output logic              i_hit,
    output logic              i_miss,
    output logic              i_inval,
    output logic [PA_W-1:0]   i_pa,
    output logic              i_dirty,
    input  logic              d_req,
    input  logic [VA_W-1:0]   d_va,
    input  logic              d_store,
    output logic              d_ack,
    output logic              d_hit,
    output logic              d_miss,
    output logic              d_inval,
    output logic              d_mod,
    output logic [PA_W-1:0]   d_pa,
    output logic              d_dirty,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN2_W-1:0] wr_vpn2,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [SZ_W-1:0]   wr_size,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic              wr_valid_even,
    input  logic              wr_dirty_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic              wr_valid_odd,
    input  logic              wr_dirty_odd,
    input  logic              pr_req,
    input  logic [VA_W-1:0]   pr_va,
    output logic              pr_ack,
    output logic              pr_hit,
    output logic [IDX_W-1:0]  pr_idx
);

    logic              e_present [ENTRIES];
    logic [VPN2_W-1:0] e_vpn2    [ENTRIES];
    logic [ASID_W-1:0] e_asid    [ENTRIES];
    logic              e_glob    [ENTRIES];
    logic [SZ_W-1:0]   e_sz      [ENTRIES];
    logic [PFN_W-1:0]  e_pfn_e   [ENTRIES];
    logic              e_v_e     [ENTRIES];
    logic              e_d_e     [ENTRIES];
    logic [PFN_W-1:0]  e_pfn_o   [ENTRIES];
    logic              e_v_o     [ENTRIES];
    logic              e_d_o     [ENTRIES];

    logic [ENTRIES-1:0] i_match;
    logic [ENTRIES-1:0] d_match;
    logic [ENTRIES-1:0] p_match;
    logic               i_mod;
    logic               pr_found;
    logic [IDX_W-1:0]   pr_sel;

    ptlb_entry_store #(.N(ENTRIES), .PFN_W(PFN_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_vpn2  (wr_vpn2),
        .wr_asid  (wr_asid),
        .wr_global(wr_global),
        .wr_size  (wr_size),
        .wr_pfn_e (wr_pfn_even),
        .wr_v_e   (wr_valid_even),
        .wr_d_e   (wr_dirty_even),
        .wr_pfn_o (wr_pfn_odd),
        .wr_v_o   (wr_valid_odd),
        .wr_d_o   (wr_dirty_odd),
        .present  (e_present),
        .vpn2     (e_vpn2),
        .asid     (e_asid),
        .glob     (e_glob),
        .sz       (e_sz),
        .pfn_e    (e_pfn_e),
        .v_e      (e_v_e),
        .d_e      (e_d_e),
        .pfn_o    (e_pfn_o),
        .v_o      (e_v_o),
        .d_o      (e_d_o)
    );

    ptlb_cam_match #(.N(ENTRIES)) cam_ifetch_i (
        .q_vpn2   (i_va[VA_W-1:TAG_LSB]),
        .q_asid   (cur_asid),
        .present  (e_present),
        .vpn2     (e_vpn2),
        .asid     (e_asid),
        .glob     (e_glob),
        .sz       (e_sz),
        .match_vec(i_match)
    );

    ptlb_cam_match #(.N(ENTRIES)) cam_data_i (
        .q_vpn2   (d_va[VA_W-1:TAG_LSB]),
        .q_asid   (cur_asid),
        .present  (e_present),
        .vpn2     (e_vpn2),
        .asid     (e_asid),
        .glob     (e_glob),
        .sz       (e_sz),
        .match_vec(d_match)
    );

    ptlb_cam_match #(.N(ENTRIES)) cam_probe_i (
        .q_vpn2   (pr_va[VA_W-1:TAG_LSB]),
        .q_asid   (cur_asid),
        .present  (e_present),
        .vpn2     (e_vpn2),
        .asid     (e_asid),
        .glob     (e_glob),
        .sz       (e_sz),
        .match_vec(p_match)
    );

    ptlb_port_resolve #(.N(ENTRIES), .PA_W(PA_W)) res_ifetch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (i_req),
        .va       (i_va),
        .store    (1'b0),
        .match_vec(i_match),
        .sz       (e_sz),
        .pfn_e    (e_pfn_e),
        .v_e      (e_v_e),
        .d_e      (e_d_e),
        .pfn_o    (e_pfn_o),
        .v_o      (e_v_o),
        .d_o      (e_d_o),
        .o_ack    (i_ack),
        .o_hit    (i_hit),
        .o_miss   (i_miss),
        .o_inval  (i_inval),
        .o_mod    (i_mod),
        .o_pa     (i_pa),
        .o_dirty  (i_dirty)
    );

    ptlb_port_resolve #(.N(ENTRIES), .PA_W(PA_W)) res_data_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (d_req),
        .va       (d_va),
        .store    (d_store),
        .match_vec(d_match),
        .sz       (e_sz),
        .pfn_e    (e_pfn_e),
        .v_e      (e_v_e),
        .d_e      (e_d_e),
        .pfn_o    (e_pfn_o),
        .v_o      (e_v_o),
        .d_o      (e_d_o),
        .o_ack    (d_ack),
        .o_hit    (d_hit),
        .o_miss   (d_miss),
        .o_inval  (d_inval),
        .o_mod    (d_mod),
        .o_pa     (d_pa),
        .o_dirty  (d_dirty)
    );

    // Lowest matching index for the probe, valid bits not consulted.
    always_comb begin
        pr_found = 1'b0;
        pr_sel   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (p_match[i]) begin
                pr_found = 1'b1;
                pr_sel   = IDX_W'(i);
            end
        end
    end

    // Register the probe answer one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_ack <= 1'b0;
            pr_hit <= 1'b0;
            pr_idx <= '0;
        end else begin
            pr_ack <= pr_req;
            pr_hit <= pr_req && pr_found;
            pr_idx <= (pr_req && pr_found) ? pr_sel : '0;
        end
    end

    // R11: probe answers one cycle after its request, and only then.
    p_probe_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pr_req |=> pr_ack);
    p_probe_hit_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pr_hit |-> $past(pr_req) && pr_ack);

    // R12: the fetch port never reports a modified fault.
    p_ifetch_no_mod_r12: assert property (@(posedge clk) disable iff (!rst_n)
        i_ack |-> !i_mod);

endmodule

// File: tb/ptlb_top_tb_top.sv
// Bench: behavioural reference model of the translation buffer, compared
// against the design on every clock for both lookup ports and the probe.
module ptlb_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;
    localparam int IW         = $clog2(N);
    localparam int WD_CYCLES  = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cur_asid = 8'h21;
    logic        i_req = 0, d_req = 0, d_store = 0, pr_req = 0;
    logic [31:0] i_va = 0, d_va = 0, pr_va = 0;
    logic        i_ack, i_hit, i_miss, i_inval, i_dirty;
    logic [31:0] i_pa;
    logic        d_ack, d_hit, d_miss, d_inval, d_mod, d_dirty;
    logic [31:0] d_pa;
    logic        wr_en = 0;
    logic [IW-1:0] wr_idx = 0;
    logic [18:0] wr_vpn2 = 0;
    logic [7:0]  wr_asid = 0;
    logic        wr_global = 0;
    logic [3:0]  wr_size = 0;
    logic [19:0] wr_pfn_even = 0, wr_pfn_odd = 0;
    logic        wr_valid_even = 0, wr_dirty_even = 0;
    logic        wr_valid_odd = 0, wr_dirty_odd = 0;
    logic        pr_ack, pr_hit;
    logic [IW-1:0] pr_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptlb_top #(.ENTRIES(N), .PA_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid),
        .i_req(i_req), .i_va(i_va), .i_ack(i_ack), .i_hit(i_hit),
        .i_miss(i_miss), .i_inval(i_inval), .i_pa(i_pa), .i_dirty(i_dirty),
        .d_req(d_req), .d_va(d_va), .d_store(d_store), .d_ack(d_ack),
        .d_hit(d_hit), .d_miss(d_miss), .d_inval(d_inval), .d_mod(d_mod),
        .d_pa(d_pa), .d_dirty(d_dirty),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_asid(wr_asid),
        .wr_global(wr_global), .wr_size(wr_size),
        .wr_pfn_even(wr_pfn_even), .wr_valid_even(wr_valid_even),
        .wr_dirty_even(wr_dirty_even), .wr_pfn_odd(wr_pfn_odd),
        .wr_valid_odd(wr_valid_odd), .wr_dirty_odd(wr_dirty_odd),
        .pr_req(pr_req), .pr_va(pr_va), .pr_ack(pr_ack), .pr_hit(pr_hit),
        .pr_idx(pr_idx)
    );

    // Reference model state.
    bit          m_pres [N];
    int unsigned m_vpn2 [N];
    int unsigned m_asid [N];
    bit          m_glob [N];
    int          m_sz   [N];
    int unsigned m_pfn  [N][2];
    bit          m_v    [N][2];
    bit          m_d    [N][2];

    // Expected registered results (kind: 0 miss, 1 hit, 2 inval, 3 mod).
    bit          e_i_ack, e_d_ack, e_p_ack, e_p_hit;
    int          e_i_kind, e_d_kind, e_p_idx;
    logic [31:0] e_i_pa, e_d_pa;
    bit          e_i_dirty, e_d_dirty;

    function automatic int find_entry(input logic [31:0] va, input logic [7:0] asid);
        for (int i = 0; i < N; i++) begin
            longint unsigned vsh, tsh;
            vsh = longint'(va) >> (13 + 2 * m_sz[i]);
            tsh = longint'(m_vpn2[i]) >> (2 * m_sz[i]);
            if (m_pres[i] && vsh == tsh && (m_glob[i] || m_asid[i] == asid))
                return i;
        end
        return -1;
    endfunction

    task automatic mdl_look(input logic [31:0] va, input bit store,
                            output int kind, output logic [31:0] pa, output bit dirty);
        int e;
        int sh;
        int h;
        longint unsigned base, offm;
        e = find_entry(va, cur_asid);
        kind = 0; pa = 0; dirty = 0;
        if (e >= 0) begin
            sh = 12 + 2 * m_sz[e];
            h  = int'((longint'(va) >> sh) & 1);
            if (!m_v[e][h]) kind = 2;
            else if (store && !m_d[e][h]) kind = 3;
            else begin
                kind  = 1;
                offm  = (64'd1 << sh) - 1;
                base  = (longint'(m_pfn[e][h]) << 12) & ~offm;
                pa    = 32'(base | (longint'(va) & offm));
                dirty = m_d[e][h];
            end
        end
    endtask

    task automatic note(input bit ok, input string tag, input string what,
                        input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    // One clock: compute expectations, apply write to model, compare.
    task automatic tick(input string tag);
        logic [31:0] pa;
        int kind;
        bit dty;
        int pi;
        e_i_ack = i_req; e_d_ack = d_req; e_p_ack = pr_req;
        mdl_look(i_va, 1'b0, kind, pa, dty);
        e_i_kind = i_req ? kind : -1; e_i_pa = i_req ? pa : 0; e_i_dirty = i_req & dty;
        mdl_look(d_va, d_store, kind, pa, dty);
        e_d_kind = d_req ? kind : -1; e_d_pa = d_req ? pa : 0; e_d_dirty = d_req & dty;
        pi = find_entry(pr_va, cur_asid);
        e_p_hit = pr_req && pi >= 0;
        e_p_idx = e_p_hit ? pi : 0;
        @(posedge clk);
        if (wr_en && int'(wr_idx) < N) begin
            m_pres[wr_idx] = 1;
            m_vpn2[wr_idx] = wr_vpn2;
            m_asid[wr_idx] = wr_asid;
            m_glob[wr_idx] = wr_global;
            m_sz[wr_idx]   = (wr_size > 8) ? 8 : int'(wr_size);
            m_pfn[wr_idx][0] = wr_pfn_even; m_v[wr_idx][0] = wr_valid_even; m_d[wr_idx][0] = wr_dirty_even;
            m_pfn[wr_idx][1] = wr_pfn_odd;  m_v[wr_idx][1] = wr_valid_odd;  m_d[wr_idx][1] = wr_dirty_odd;
        end
        @(negedge clk);
        begin
            logic [63:0] gi, xi, gd, xd, gp, xp;
            gi = {i_ack, i_hit, i_miss, i_inval, i_dirty, i_pa};
            xi = {e_i_ack, e_i_kind == 1, e_i_kind == 0, e_i_kind == 2, e_i_dirty, e_i_pa};
            gd = {d_ack, d_hit, d_miss, d_inval, d_mod, d_dirty, d_pa};
            xd = {e_d_ack, e_d_kind == 1, e_d_kind == 0, e_d_kind == 2, e_d_kind == 3, e_d_dirty, e_d_pa};
            gp = {pr_ack, pr_hit, 4'(pr_idx)};
            xp = {e_p_ack, e_p_hit, 4'(e_p_idx)};
            note(gi == xi, tag, "ifetch", gi, xi);
            note(gd == xd, tag, "data", gd, xd);
            note(gp == xp, tag, "probe", gp, xp);
        end
        i_req = 0; d_req = 0; d_store = 0; pr_req = 0; wr_en = 0;
    endtask

    task automatic set_write(input int idx, input int unsigned vpn2, input int unsigned asid,
                             input bit g, input int sz, input int unsigned pe, input bit ve,
                             input bit de, input int unsigned po, input bit vo, input bit dd);
        wr_en = 1; wr_idx = IW'(idx); wr_vpn2 = 19'(vpn2); wr_asid = 8'(asid);
        wr_global = g; wr_size = 4'(sz);
        wr_pfn_even = 20'(pe); wr_valid_even = ve; wr_dirty_even = de;
        wr_pfn_odd = 20'(po);  wr_valid_odd = vo;  wr_dirty_odd = dd;
    endtask

    // Virtual address inside a pair tag, choosing the half and a random offset.
    function automatic logic [31:0] mk_va(input int unsigned vpn2, input int sz, input bit odd);
        longint unsigned hi, lo;
        int sh;
        sh = 12 + 2 * ((sz > 8) ? 8 : sz);
        hi = (longint'(vpn2) << 13) & ~((64'd1 << (sh + 1)) - 1);
        lo = longint'($urandom) & ((64'd1 << sh) - 1);
        return 32'(hi | (longint'(odd) << sh) | lo);
    endfunction

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: quiet outputs after reset.
        note({i_ack, i_hit, d_ack, d_hit, pr_ack, pr_hit} == 0, "R1", "reset outputs",
             {i_ack, i_hit, d_ack, d_hit, pr_ack, pr_hit}, 0);
        // R1: every lookup and probe misses on the empty array.
        for (int k = 0; k < 4; k++) begin
            i_req = 1; i_va = $urandom; d_req = 1; d_va = (k == 0) ? 0 : $urandom;
            pr_req = 1; pr_va = 0;
            tick("R1");
        end
        // R2: write and lookup in the same cycle, then the next cycle.
        set_write(3, 19'h1234, 8'h21, 0, 0, 20'hABCDE, 1, 1, 20'h12345, 1, 0);
        d_req = 1; d_va = mk_va(19'h1234, 0, 0); pr_req = 1; pr_va = d_va;
        tick("R2");
        d_req = 1; d_va = mk_va(19'h1234, 0, 0); pr_req = 1; pr_va = d_va;
        tick("R2");
        set_write(20, 1, 1, 1, 0, 1, 1, 1, 1, 1, 1);
        wr_idx = IW'(N - 1);
        tick("R2");
        // R4 / R5 / R6: every size code, both halves, random offsets.
        for (int k = 0; k < 10; k++) begin
            int unsigned tg;
            int sc;
            tg = $urandom & 19'h7FFFF;
            sc = (k == 9) ? 13 : k;
            set_write(k, tg, 8'h21, 0, sc, $urandom, 1, 1, $urandom, 1, 1);
            tick("R4");
            i_req = 1; i_va = mk_va(tg, sc, 0); d_req = 1; d_va = mk_va(tg, sc, 0);
            tick("R4");
            i_req = 1; i_va = mk_va(tg, sc, 1); d_req = 1; d_va = mk_va(tg, sc, 1);
            tick("R5");
            i_req = 1; i_va = mk_va(tg, sc, 1); d_req = 1; d_va = mk_va(tg, sc, 0);
            pr_req = 1; pr_va = mk_va(tg, sc, 1);
            tick("R6");
        end
        // R3: identifier mismatch misses, global entry matches any identifier.
        set_write(10, 19'h0F0F0, 8'h55, 0, 1, 20'h11111, 1, 1, 20'h22222, 1, 1);
        tick("R3");
        set_write(11, 19'h0A0A0, 8'h66, 1, 0, 20'h33333, 1, 1, 20'h44444, 1, 1);
        d_req = 1; d_va = mk_va(19'h0F0F0, 1, 0); i_req = 1; i_va = d_va;
        tick("R3");
        d_req = 1; d_va = mk_va(19'h0A0A0, 0, 1); i_req = 1; i_va = mk_va(19'h0A0A0, 0, 0);
        tick("R3");
        cur_asid = 8'h55;
        d_req = 1; d_va = mk_va(19'h0F0F0, 1, 1); pr_req = 1; pr_va = d_va;
        tick("R3");
        cur_asid = 8'h21;
        // R7 / R8: invalid half, store to clean half, load of clean half.
        set_write(12, 19'h05050, 8'h21, 0, 2, 20'h55555, 0, 1, 20'h66666, 1, 0);
        tick("R7");
        d_req = 1; d_va = mk_va(19'h05050, 2, 0); i_req = 1; i_va = d_va; pr_req = 1; pr_va = d_va;
        tick("R7");
        d_req = 1; d_store = 1; d_va = mk_va(19'h05050, 2, 1); i_req = 1; i_va = d_va;
        tick("R8");
        d_req = 1; d_store = 0; d_va = mk_va(19'h05050, 2, 1);
        tick("R8");
        // R10 / R11: duplicate tags, lowest index wins.
        set_write(14, 19'h07777, 8'h21, 0, 0, 20'hAAAAA, 1, 1, 20'hBBBBB, 1, 1);
        tick("R10");
        set_write(13, 19'h07777, 8'h21, 0, 0, 20'hCCCCC, 1, 0, 20'hDDDDD, 0, 1);
        tick("R10");
        d_req = 1; d_va = mk_va(19'h07777, 0, 0); i_req = 1; i_va = mk_va(19'h07777, 0, 1);
        pr_req = 1; pr_va = d_va;
        tick("R10");
        pr_req = 1; pr_va = mk_va(19'h07777, 0, 1);
        tick("R11");
        pr_req = 1; pr_va = 32'hFFFF_F000;
        tick("R11");
        // R9 / R12: both ports busy with random traffic and writes.
        for (int c = 0; c < 3000; c++) begin
            int e;
            e = $urandom_range(N - 1);
            if ($urandom_range(4) == 0)
                set_write($urandom_range(N - 1), $urandom & 19'h000FF, 8'h21 + $urandom_range(1),
                          $urandom_range(3) == 0, $urandom_range(10), $urandom, $urandom_range(5) != 0,
                          $urandom_range(1), $urandom, $urandom_range(5) != 0, $urandom_range(1));
            i_req = $urandom_range(3) != 0;
            i_va  = m_pres[e] ? mk_va(m_vpn2[e], m_sz[e], $urandom_range(1)) : $urandom;
            e = $urandom_range(N - 1);
            d_req = $urandom_range(3) != 0;
            d_store = d_req && $urandom_range(1);
            d_va  = m_pres[e] ? mk_va(m_vpn2[e], m_sz[e], $urandom_range(1)) : $urandom;
            pr_req = $urandom_range(2) == 0;
            pr_va = d_va;
            cur_asid = ($urandom_range(7) == 0) ? 8'h22 : 8'h21;
            tick((c % 2 == 0) ? "R9" : "R12");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule